// File: doc/BRIEF.md
# Column-Strobed Simple Dual-Port RAM

This block is a synchronous line memory with one write port and one or two read ports. A line is split into equal-width columns. Each column has its own write strobe, so a single write can update any subset of a line and leave the other columns unchanged. Reads are registered. A read request captured at a clock edge puts the addressed line on the read output at that same edge, so the data can be used in the following cycle. While no read is requested, the output holds its last value.

A read and a write can hit the same line in the same cycle. The `WRITE_FIRST` parameter sets what the read returns in that case. With write-first, the read returns the freshly written columns, and the columns without a strobe keep their stored value. With read-first, the read returns the whole line as it was before the write. With `DUAL_READ` set, a second independent read port is added. It is built from a duplicate storage copy that receives every write, so both ports always see the same contents.

Top module: `colmask_ram`

## Requirements
- R1: While `rstN` is low, both read data outputs are zero. They stay zero after release until a read is performed.
- R2: When a read enable is high at a clock edge, the read data output of that port shows the addressed line after that edge.
- R3: When a read enable is low at a clock edge, the read data output of that port keeps its previous value.
- R4: Strobe bit c of `wrEn` (LSB = column 0) guards line bits [c*COL_W +: COL_W]. Only the columns whose strobe is set are written at `wrAddr`. The other columns of that line keep their contents.
- R5: A write cycle with `wrEn` all zero changes no stored line.
- R6: With `WRITE_FIRST`=1, a read whose address equals the write address in the same cycle returns the new data in the strobed columns and the previously stored data in the other columns.
- R7: With `WRITE_FIRST`=0, a same-cycle same-address read returns the whole line as stored before the write. A later read returns the written data.
- R8: With `DUAL_READ`=1, ports A and B read independently. Reading the same address on both ports in the same cycle yields identical data.
- R9: With `DUAL_READ`=0, `rdDataB` stays zero and port B inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the read registers |
| wrEn | input | NB_COL | Per-column write strobes |
| wrAddr | input | ADDR_W | Write line address |
| wrData | input | NB_COL*COL_W | Write data |
| rdEnA | input | 1 | Read request, port A |
| rdAddrA | input | ADDR_W | Read address, port A |
| rdDataA | output | NB_COL*COL_W | Registered read data, port A |
| rdEnB | input | 1 | Read request, port B |
| rdAddrB | input | ADDR_W | Read address, port B |
| rdDataB | output | NB_COL*COL_W | Registered read data, port B (zero when single-port) |

## Verification
The bench drives two instances in parallel: a write-first, two-port copy and a read-first, one-port copy. A single reference array predicts the output of both. A fixed vector table covers full-line writes, a partial strobe that collides with a read (which separates column-wise merge from whole-line forwarding), a zero-strobe write and idle read cycles that must hold the output. A random phase then mixes strobe patterns and addresses from a small range, so that collisions occur often. These collisions separate write-first merging from read-first old data, and they test the agreement between the two ports on shared addresses.

// File: rtl/colram_pkg.sv
package colram_pkg;

  // Per-read-port strobes passed from control to datapath
  typedef struct packed {
    logic rdEn;    // capture a new line this cycle
    logic bypass;  // same-address write this cycle, forward strobed columns
  } rdStrobe_t;

endpackage

// File: rtl/colram_ctrl.sv
module colram_ctrl
  import colram_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int NB_COL      = 4,
  parameter bit WRITE_FIRST = 1'b1,
  parameter int NUM_RD      = 2
) (
  input  logic [NB_COL-1:0]              wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [NUM_RD-1:0]              rdEn,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  rdAddr,
  output rdStrobe_t [NUM_RD-1:0]         strobe
);

  logic wrAny;
  assign wrAny = |wrEn;

  for (genvar r = 0; r < NUM_RD; r++) begin : g_port
    logic addrHit;
    assign addrHit = wrAny && (wrAddr == rdAddr[r]);
    assign strobe[r].rdEn = rdEn[r];
    if (WRITE_FIRST) begin : g_wf
      assign strobe[r].bypass = rdEn[r] && addrHit;
    end else begin : g_rf
      // read-first: the stored line is sampled before the write lands
      assign strobe[r].bypass = 1'b0;
    end
  end

endmodule

// File: rtl/colram_bank.sv
module colram_bank
  import colram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int COL_W  = 8,
  parameter int NB_COL = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NB_COL-1:0]        wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [NB_COL*COL_W-1:0]  wrData,
  input  rdStrobe_t                strobe,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [NB_COL*COL_W-1:0]  rdData
);

  localparam int LINE_W = NB_COL * COL_W;

  logic [LINE_W-1:0] mem [DEPTH];
  logic [LINE_W-1:0] storedLine;
  logic [LINE_W-1:0] nextLine;

  // Column-strobed write
  always_ff @(posedge clk) begin
    for (int c = 0; c < NB_COL; c++) begin
      if (wrEn[c]) mem[wrAddr][c*COL_W +: COL_W] <= wrData[c*COL_W +: COL_W];
    end
  end

  assign storedLine = mem[rdAddr];

  // Column merge for same-cycle forwarding
  for (genvar c = 0; c < NB_COL; c++) begin : g_col
    assign nextLine[c*COL_W +: COL_W] = (strobe.bypass && wrEn[c])
                                        ? wrData[c*COL_W +: COL_W]
                                        : storedLine[c*COL_W +: COL_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= nextLine;
  end

endmodule

// File: rtl/colmask_ram.sv
module colmask_ram
  import colram_pkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int ADDR_W      = $clog2(DEPTH),
  parameter int COL_W       = 8,
  parameter int NB_COL      = 4,
  parameter bit WRITE_FIRST = 1'b1,
  parameter bit DUAL_READ   = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NB_COL-1:0]        wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [NB_COL*COL_W-1:0]  wrData,
  input  logic                     rdEnA,
  input  logic [ADDR_W-1:0]        rdAddrA,
  output logic [NB_COL*COL_W-1:0]  rdDataA,
  input  logic                     rdEnB,
  input  logic [ADDR_W-1:0]        rdAddrB,
  output logic [NB_COL*COL_W-1:0]  rdDataB
);

  localparam int LINE_W = NB_COL * COL_W;
  localparam int NUM_RD = DUAL_READ ? 2 : 1;

  logic [1:0]                      rdEnAll;
  logic [1:0][ADDR_W-1:0]          rdAddrAll;
  logic [NUM_RD-1:0][LINE_W-1:0]   rdDataVec;
  rdStrobe_t [NUM_RD-1:0]          strobe;

  assign rdEnAll   = {rdEnB, rdEnA};
  assign rdAddrAll = {rdAddrB, rdAddrA};

  colram_ctrl #(
    .ADDR_W(ADDR_W), .NB_COL(NB_COL), .WRITE_FIRST(WRITE_FIRST), .NUM_RD(NUM_RD)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr),
    .rdEn(rdEnAll[NUM_RD-1:0]), .rdAddr(rdAddrAll[NUM_RD-1:0]),
    .strobe(strobe)
  );

  // One storage copy per read port, all sharing the write port
  for (genvar r = 0; r < NUM_RD; r++) begin : g_copy
    colram_bank #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .COL_W(COL_W), .NB_COL(NB_COL)
    ) u_bank (
      .clk(clk), .rstN(rstN),
      .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
      .strobe(strobe[r]), .rdAddr(rdAddrAll[r]),
      .rdData(rdDataVec[r])
    );
  end

  assign rdDataA = rdDataVec[0];

  if (DUAL_READ) begin : g_portb
    assign rdDataB = rdDataVec[NUM_RD-1];
  end else begin : g_nob
    assign rdDataB = '0;
  end

endmodule

// File: rtl/colmask_ram_chk.sv
module colmask_ram_chk #(
  parameter int ADDR_W      = 10,
  parameter int COL_W       = 8,
  parameter int NB_COL      = 4,
  parameter bit WRITE_FIRST = 1'b1,
  parameter bit DUAL_READ   = 1'b1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NB_COL-1:0]        wrEn,
  input logic [ADDR_W-1:0]        wrAddr,
  input logic [NB_COL*COL_W-1:0]  wrData,
  input logic                     rdEnA,
  input logic [ADDR_W-1:0]        rdAddrA,
  input logic [NB_COL*COL_W-1:0]  rdDataA,
  input logic                     rdEnB,
  input logic [ADDR_W-1:0]        rdAddrB,
  input logic [NB_COL*COL_W-1:0]  rdDataB
);

  a_r3_hold_a: assert property (@(posedge clk) disable iff (!rstN)
    !rdEnA |=> $stable(rdDataA));

  a_r3_hold_b: assert property (@(posedge clk) disable iff (!rstN)
    !rdEnB |=> $stable(rdDataB));

  if (WRITE_FIRST) begin : g_wf
    for (genvar c = 0; c < NB_COL; c++) begin : g_col
      a_r6_forward_col: assert property (@(posedge clk) disable iff (!rstN)
        (rdEnA && wrEn[c] && wrAddr == rdAddrA)
        |=> rdDataA[c*COL_W +: COL_W] == $past(wrData[c*COL_W +: COL_W]));
    end
  end

  if (DUAL_READ) begin : g_dual
    a_r8_ports_agree: assert property (@(posedge clk) disable iff (!rstN)
      (rdEnA && rdEnB && rdAddrA == rdAddrB) |=> rdDataA == rdDataB);
  end else begin : g_single
    a_r9_b_quiet: assert property (@(posedge clk) disable iff (!rstN)
      rdDataB == '0);
  end

endmodule

bind colmask_ram colmask_ram_chk #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .NB_COL(NB_COL),
  .WRITE_FIRST(WRITE_FIRST), .DUAL_READ(DUAL_READ)
) u_chk (.*);

// File: tb/tb_colmask_ram.sv
`timescale 1ns/1ps
module tb_colmask_ram;

  localparam int AW = 10;
  localparam int NC = 4;
  localparam int CW = 8;
  localparam int LW = NC * CW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NC-1:0] wrEn = '0;
  logic [AW-1:0] wrAddr = '0;
  logic [LW-1:0] wrData = '0;
  logic          rdEnA = 1'b0, rdEnB = 1'b0;
  logic [AW-1:0] rdAddrA = '0, rdAddrB = '0;
  logic [LW-1:0] wfA, wfB, rfA, rfB;

  always #2 clk = ~clk;  // 250 MHz

  colmask_ram #(.WRITE_FIRST(1'b1), .DUAL_READ(1'b1)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEnA(rdEnA), .rdAddrA(rdAddrA), .rdDataA(wfA),
    .rdEnB(rdEnB), .rdAddrB(rdAddrB), .rdDataB(wfB));

  colmask_ram #(.WRITE_FIRST(1'b0), .DUAL_READ(1'b0)) dutRf (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEnA(rdEnA), .rdAddrA(rdAddrA), .rdDataA(rfA),
    .rdEnB(rdEnB), .rdAddrB(rdAddrB), .rdDataB(rfB));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [LW-1:0] refMem [1024];
  logic [LW-1:0] prevWfA = '0, prevWfB = '0, prevRfA = '0;

  typedef struct packed {
    logic [NC-1:0] we;
    logic [AW-1:0] wa;
    logic [LW-1:0] wd;
    logic          re;
    logic [AW-1:0] ra;
    logic [LW-1:0] exp;  // expected write-first port A output
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{4'hF, 10'd1, 32'h11223344, 1'b0, 10'd0, 32'h00000000},  // R3 idle keeps reset value
    '{4'hF, 10'd2, 32'hAABBCCDD, 1'b1, 10'd1, 32'h11223344},  // R2 plain read
    '{4'h5, 10'd2, 32'h12345678, 1'b1, 10'd2, 32'hAA34CC78},  // R6 partial collision merge
    '{4'h0, 10'd2, 32'hFFFFFFFF, 1'b1, 10'd2, 32'hAA34CC78},  // R5 zero strobe
    '{4'hF, 10'd3, 32'hCAFEF00D, 1'b1, 10'd3, 32'hCAFEF00D},  // R6 full collision
    '{4'h0, 10'd0, 32'h00000000, 1'b0, 10'd1, 32'hCAFEF00D},  // R3 hold
    '{4'h8, 10'd1, 32'h99000000, 1'b1, 10'd1, 32'h99223344},  // R4 top column only
    '{4'h0, 10'd0, 32'h00000000, 1'b1, 10'd3, 32'hCAFEF00D}   // R2 reread
  };

  task automatic check(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] wfRead(input logic [AW-1:0] ra, input logic [NC-1:0] we,
                                           input logic [AW-1:0] wa, input logic [LW-1:0] wd);
    logic [LW-1:0] r;
    r = refMem[ra];
    for (int c = 0; c < NC; c++)
      if (we[c] && wa == ra) r[c*CW +: CW] = wd[c*CW +: CW];
    return r;
  endfunction

  task automatic step(input logic [NC-1:0] we, input logic [AW-1:0] wa, input logic [LW-1:0] wd,
                      input logic reA, input logic [AW-1:0] raA,
                      input logic reB, input logic [AW-1:0] raB);
    logic [LW-1:0] eWfA, eWfB, eRfA;
    string tagA, tagB, tagR;
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd;
    rdEnA = reA; rdAddrA = raA; rdEnB = reB; rdAddrB = raB;
    eWfA = reA ? wfRead(raA, we, wa, wd) : prevWfA;
    eWfB = reB ? wfRead(raB, we, wa, wd) : prevWfB;
    eRfA = reA ? refMem[raA] : prevRfA;
    tagA = !reA ? "R3 hold A" : ((|we && wa == raA) ? "R6 write-first collision A" : "R2 read A");
    tagB = !reB ? "R3 hold B" : ((|we && wa == raB) ? "R6 write-first collision B" : "R8 read B");
    tagR = !reA ? "R3 hold read-first" : ((|we && wa == raA) ? "R7 read-first collision" : "R2 read-first");
    for (int c = 0; c < NC; c++)
      if (we[c]) refMem[wa][c*CW +: CW] = wd[c*CW +: CW];
    @(posedge clk); #1;
    check(tagA, wfA, eWfA);
    check(tagB, wfB, eWfB);
    check(tagR, rfA, eRfA);
    check("R9 unused port B zero", rfB, '0);
    prevWfA = eWfA; prevWfB = eWfB; prevRfA = eRfA;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset A", wfA, '0);
    check("R1 reset B", wfB, '0);
    check("R1 reset read-first", rfA, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", wfA, '0);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      step(VEC[i].we, VEC[i].wa, VEC[i].wd, VEC[i].re, VEC[i].ra, 1'b0, '0);
      check($sformatf("table row %0d", i), wfA, VEC[i].exp);
    end

    // Preload lines 0..7
    for (int a = 0; a < 8; a++)
      step(4'hF, AW'(a), {4{8'(8'h11 * a)}}, 1'b0, '0, 1'b0, '0);

    // R7: read-first collision returns old line, later read returns new
    step(4'hF, 10'd6, 32'hDEADBEEF, 1'b1, 10'd6, 1'b0, '0);
    check("R7 old line", rfA, 32'h66666666);
    step(4'h0, 10'd0, '0, 1'b1, 10'd6, 1'b0, '0);
    check("R7 new line later", rfA, 32'hDEADBEEF);

    // R4: single middle column
    step(4'h2, 10'd4, 32'h0000AB00, 1'b0, '0, 1'b0, '0);
    step(4'h0, 10'd0, '0, 1'b1, 10'd4, 1'b1, 10'd4);
    check("R4 column strobe", wfA, 32'h4444AB44);
    check("R8 same address both ports", wfB, wfA);

    // R5: zero strobe with data on bus
    step(4'h0, 10'd5, 32'hFFFFFFFF, 1'b0, '0, 1'b0, '0);
    step(4'h0, 10'd0, '0, 1'b1, 10'd5, 1'b1, 10'd7);
    check("R5 zero strobe", wfA, 32'h55555555);
    check("R8 independent port B", wfB, 32'h77777777);

    // Random mix
    for (int i = 0; i < 400; i++)
      step(NC'($urandom), AW'($urandom_range(0, 7)), $urandom,
           1'($urandom), AW'($urandom_range(0, 7)),
           1'($urandom), AW'($urandom_range(0, 7)));

    finishRun();
  end

endmodule